// File: doc/BRIEF.md
# Pin-Sequence Diagnostic Mode Controller

This block decodes mode changes for an LED sink driver from its two control lines, the latch strobe and the active-low output enable, so no dedicated pin is needed. On every rising clock edge it samples both lines. It watches for two fixed five-edge patterns. The entry pattern moves the block into detection mode and the resume pattern moves it back to normal mode. The two patterns must strictly alternate, so a pattern that does not fit the current mode does nothing.

In detection mode the host latches all-ones data and then drives the output enable low for the test window. The block counts the low period in clock cycles against a parameter that stands for 1 µs. At each low sample it keeps a copy of the per-channel open and short comparator flags. When the enable returns high after a window of full length, the block builds a status word from that copy. It then raises a one-cycle load strobe so the shift chain can take the word in parallel. The shift chain always accepts the strobe, so the load has no back-pressure. Only one result is produced per visit to detection mode. A new test needs a resume and then a new entry.

Top module: `diag_mode_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `diag_mode` is 0, `stat_load` is 0 and `stat_word` is all zeros.
- R2: Five consecutive edges with `out_en_n` = 1,0,1,1,1 and `latch_en` = 0,0,0,1,0 (oldest first) set `diag_mode` in normal mode. The flag is high directly after the fifth edge, so it reads 1 from the sixth edge on. After only four of the five edges it is still 0.
- R3: In detection mode, five consecutive edges with `out_en_n` = 1,0,1,1,1 and `latch_en` held at 0 clear `diag_mode` directly after the fifth edge.
- R4: A pattern is recognized only when all five of its samples are consecutive. A differing sample spoils that attempt, and recognition can restart on any later edge. The samples of a completed pattern are consumed and never count toward the next pattern.
- R5: The entry pattern in detection mode and the resume pattern in normal mode leave `diag_mode` unchanged. An ignored entry does not re-arm a new result.
- R6: In detection mode, suppose `out_en_n` is sampled low on at least `WIN_CYCLES` consecutive edges and then sampled high. `stat_load` is then 1 for exactly the one cycle after that high edge, and it is 0 at all other times, including during the window.
- R7: Bit i of the loaded `stat_word` is `open_flag[i] | short_flag[i]`, taken at the last edge on which `out_en_n` was sampled low. Flag values present at the closing edge are not used.
- R8: A low period shorter than `WIN_CYCLES` edges produces no load and leaves `stat_word` unchanged. A later full window in the same visit still loads.
- R9: At most one load is made per visit to detection mode. Further full windows are ignored until a resume and a new entry.
- R10: In normal mode, low periods of any length on `out_en_n` produce no load.
- R11: `stat_word` holds its value except in the cycle in which `stat_load` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both control lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| latch_en | input | 1 | Latch strobe line, also decoded as a pattern input |
| out_en_n | input | 1 | Active-low output enable, also the pattern input and the window gate |
| open_flag | input | NCH | Per-channel flag: sensed current at or below half the programmed value |
| short_flag | input | NCH | Per-channel flag: output voltage at or above the short threshold |
| diag_mode | output | 1 | 1 while in detection mode |
| stat_load | output | 1 | One-cycle request to parallel-load `stat_word` into the shift chain |
| stat_word | output | NCH | Latest per-channel error word, one bit per channel |

## Verification
The hardest case to reach is a pattern whose leading samples are the tail of a pattern that has just completed. For example, the final sample of an entry could act as the first step of a resume. The bench builds this case on purpose: right after an entry it drives only the last four steps of a resume, checks that the mode is held, and then sends a full resume. A second hard case is the single-result rule. It is reached by running a full window, then an entry that should be ignored, then another full window within one visit. Window lengths are swept from one edge up to two past the threshold, and every channel is tried with open, short and both flags.

// File: rtl/diag_pkg.sv
package diag_pkg;
  // Pattern length; the order of samples in each pattern is behaviour.
  localparam int unsigned SEQ_LEN = 5;
  localparam int unsigned FILL_W  = $clog2(SEQ_LEN);
  // Bit k holds the sample expected at the (k+1)-th edge of a pattern.
  localparam logic [SEQ_LEN-1:0] SEQ_OE        = 5'b11101;
  localparam logic [SEQ_LEN-1:0] SEQ_LE_ENTRY  = 5'b01000;
  localparam logic [SEQ_LEN-1:0] SEQ_LE_RESUME = 5'b00000;
endpackage

// File: rtl/diag_seq_detect.sv
module diag_seq_detect
  import diag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic lat,
  output logic entry_hit,
  output logic resume_hit
);
  logic [SEQ_LEN-1:0] oe_hist, le_hist;
  logic [SEQ_LEN-1:0] oe_next, le_next;
  logic [FILL_W-1:0]  fill;
  logic               full;

  // Newest sample enters at the top, oldest sits in bit 0.
  assign oe_next = {oe_n, oe_hist[SEQ_LEN-1:1]};
  assign le_next = {lat,  le_hist[SEQ_LEN-1:1]};
  assign full    = (fill == FILL_W'(SEQ_LEN - 1));

  assign entry_hit  = full && (oe_next == SEQ_OE) && (le_next == SEQ_LE_ENTRY);
  assign resume_hit = full && (oe_next == SEQ_OE) && (le_next == SEQ_LE_RESUME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hist <= '0;
      le_hist <= '0;
      fill    <= '0;
    end else begin
      oe_hist <= oe_next;
      le_hist <= le_next;
      if (entry_hit || resume_hit) fill <= '0;
      else if (!full)              fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/diag_mode_reg.sv
module diag_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic entry_hit,
  input  logic resume_hit,
  input  logic win_ok,
  output logic diag_mode,
  output logic armed
);
  logic done;

  assign armed = !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diag_mode <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (!diag_mode && entry_hit) begin
        diag_mode <= 1'b1;
        done      <= 1'b0;
      end else if (diag_mode && resume_hit) begin
        diag_mode <= 1'b0;
      end else if (win_ok) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/diag_window_timer.sv
module diag_window_timer #(
  parameter int unsigned WIN_CYCLES = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic oe_n,
  input  logic armed,
  output logic win_low,
  output logic win_ok
);
  localparam int unsigned CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(WIN_CYCLES);

  logic [CW-1:0] cnt;
  logic          low_seen;
  logic          closing;

  assign win_low = active && !oe_n;
  assign closing = active && oe_n && low_seen;
  assign win_ok  = closing && (cnt == CMAX) && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      low_seen <= 1'b0;
    end else if (win_low) begin
      low_seen <= 1'b1;
      if (cnt != CMAX) cnt <= cnt + 1'b1;
    end else begin
      cnt      <= '0;
      low_seen <= 1'b0;
    end
  end
endmodule

// File: rtl/diag_status_capture.sv
module diag_status_capture #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           win_low,
  input  logic           win_ok,
  input  logic [NCH-1:0] open_flag,
  input  logic [NCH-1:0] short_flag,
  output logic           stat_load,
  output logic [NCH-1:0] stat_word
);
  logic [NCH-1:0] snap;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap[i] <= 1'b0;
      else if (win_low) snap[i] <= open_flag[i] | short_flag[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_word[i] <= 1'b0;
      else if (win_ok) stat_word[i] <= snap[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_load <= 1'b0;
    else        stat_load <= win_ok;
  end
endmodule

// File: rtl/diag_mode_ctrl.sv
module diag_mode_ctrl #(
  parameter int unsigned NCH        = 16,
  parameter int unsigned WIN_CYCLES = 125
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           latch_en,
  input  logic           out_en_n,
  input  logic [NCH-1:0] open_flag,
  input  logic [NCH-1:0] short_flag,
  output logic           diag_mode,
  output logic           stat_load,
  output logic [NCH-1:0] stat_word
);
  logic entry_hit, resume_hit;
  logic armed, win_low, win_ok;

  diag_seq_detect u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_n       (out_en_n),
    .lat        (latch_en),
    .entry_hit  (entry_hit),
    .resume_hit (resume_hit)
  );

  diag_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_hit  (entry_hit),
    .resume_hit (resume_hit),
    .win_ok     (win_ok),
    .diag_mode  (diag_mode),
    .armed      (armed)
  );

  diag_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (diag_mode),
    .oe_n    (out_en_n),
    .armed   (armed),
    .win_low (win_low),
    .win_ok  (win_ok)
  );

  diag_status_capture #(.NCH(NCH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_low    (win_low),
    .win_ok     (win_ok),
    .open_flag  (open_flag),
    .short_flag (short_flag),
    .stat_load  (stat_load),
    .stat_word  (stat_word)
  );
endmodule

// File: rtl/diag_mode_ctrl_chk.sv
module diag_mode_ctrl_chk #(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           latch_en,
  input logic           out_en_n,
  input logic           diag_mode,
  input logic           stat_load,
  input logic [NCH-1:0] stat_word
);
  assert_load_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_load |=> !stat_load);

  assert_load_in_diag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_load |-> diag_mode);

  assert_entry_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diag_mode) |-> ($past(out_en_n, 1) && !$past(latch_en, 1) &&
                          $past(latch_en, 2) && !$past(out_en_n, 4)));

  assert_resume_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(diag_mode) |-> ($past(out_en_n, 1) && !$past(latch_en, 1) &&
                          !$past(latch_en, 2) && !$past(out_en_n, 4)));

  assert_word_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_word) |-> stat_load);
endmodule

bind diag_mode_ctrl diag_mode_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .latch_en  (latch_en),
  .out_en_n  (out_en_n),
  .diag_mode (diag_mode),
  .stat_load (stat_load),
  .stat_word (stat_word)
);

// File: tb/sim_diag_mode_ctrl.sv
`timescale 1ns/1ps
module sim_diag_mode_ctrl;
  localparam int NCH = 16;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch_en = 1'b1;
  logic out_en_n = 1'b1;
  logic [NCH-1:0] open_flag = '0;
  logic [NCH-1:0] short_flag = '0;
  logic diag_mode, stat_load;
  logic [NCH-1:0] stat_word;

  int checks = 0;
  int errors = 0;
  bit exp_mode = 1'b0;
  bit exp_done = 1'b0;
  logic [NCH-1:0] exp_word = '0;

  always #4 clk = ~clk;

  diag_mode_ctrl #(.NCH(NCH), .WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .out_en_n(out_en_n),
    .open_flag(open_flag), .short_flag(short_flag),
    .diag_mode(diag_mode), .stat_load(stat_load), .stat_word(stat_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one sample; return at the next falling edge, after one rising edge.
  task automatic drive(input logic oe, input logic le);
    out_en_n = oe;
    latch_en = le;
    @(negedge clk);
  endtask

  task automatic enter_seq(input string req);
    for (int i = 0; i < 5; i++) begin
      drive(i != 1, i == 3);
      if (i == 3) chk({req, " before fifth edge"}, diag_mode, exp_mode);
    end
    if (!exp_mode) begin
      exp_mode = 1'b1;
      exp_done = 1'b0;
    end
    chk(req, diag_mode, exp_mode);
  endtask

  task automatic resume_seq(input string req);
    for (int i = 0; i < 5; i++) begin
      drive(i != 1, 1'b0);
      if (i == 3) chk({req, " before fifth edge"}, diag_mode, exp_mode);
    end
    exp_mode = 1'b0;
    chk(req, diag_mode, exp_mode);
    chk("R11 word held", stat_word, exp_word);
  endtask

  // len low samples; flags (o1,s1) before the last, (o2,s2) on the last one.
  task automatic run_window(input int len, input logic [NCH-1:0] o1, input logic [NCH-1:0] s1,
                            input logic [NCH-1:0] o2, input logic [NCH-1:0] s2);
    bit ld;
    for (int i = 0; i < len; i++) begin
      open_flag  = (i == len - 1) ? o2 : o1;
      short_flag = (i == len - 1) ? s2 : s1;
      drive(1'b0, 1'b0);
      chk("R6 no load during window", stat_load, 1'b0);
    end
    open_flag  = ~(o2 | s2);
    short_flag = ~(o2 | s2);
    drive(1'b1, 1'b1);
    ld = exp_mode && !exp_done && (len >= WIN);
    if (ld) begin
      exp_word = o2 | s2;
      exp_done = 1'b1;
    end
    chk(exp_mode ? "R6 R8 R9 load after window" : "R10 no load in normal mode", stat_load, ld);
    chk("R7 R8 status word", stat_word, exp_word);
    drive(1'b1, 1'b1);
    chk("R6 single-cycle strobe", stat_load, 1'b0);
    chk("R11 word held", stat_word, exp_word);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NCH-1:0] a, b;
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", diag_mode, 1'b0);
    chk("R1 load in reset", stat_load, 1'b0);
    chk("R1 word in reset", stat_word, '0);
    rst_n = 1'b1;
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b1);
    chk("R1 mode after reset", diag_mode, 1'b0);
    chk("R1 word after reset", stat_word, '0);

    // R10: long low period in normal mode
    run_window(WIN + 2, '1, '0, '1, '1);
    // R5: resume while in normal mode
    resume_seq("R5 resume ignored in normal mode");
    // R4: broken pattern
    drive(1'b1, 1'b0); drive(1'b0, 1'b0); drive(1'b0, 1'b0);
    drive(1'b1, 1'b1); drive(1'b1, 1'b0);
    chk("R4 broken pattern ignored", diag_mode, 1'b0);
    // R4: partial start, then the full entry overlapping it
    drive(1'b1, 1'b0); drive(1'b0, 1'b0); drive(1'b1, 1'b0);
    enter_seq("R2 R4 entry after partial attempt");
    // R4: completed entry's last sample must not seed a resume
    drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b0);
    chk("R4 samples of completed pattern consumed", diag_mode, 1'b1);
    resume_seq("R3 resume");

    // Window length sweep
    for (int len = 1; len <= WIN + 2; len++) begin
      a = NCH'(len * 16'h1357) ^ NCH'(16'hA5A5 >> len);
      b = NCH'(len * 16'h0F0F);
      enter_seq("R2 entry");
      run_window(len, '0, '0, a, b);
      resume_seq("R3 resume");
    end

    // R7 last-sample capture, R9 single result, R5 ignored re-entry
    enter_seq("R2 entry");
    run_window(WIN + 1, 16'h00FF, 16'h0000, 16'h1200, 16'h0034);
    run_window(WIN, 16'hFFFF, '0, 16'hFFFF, '0);
    enter_seq("R5 entry ignored in detection mode");
    run_window(WIN, 16'h0F0F, '0, 16'h0F0F, '0);
    resume_seq("R3 resume");

    // R8: short window then full window in one visit
    enter_seq("R2 entry");
    run_window(WIN - 1, 16'hAAAA, '0, 16'hAAAA, '0);
    run_window(WIN, '0, 16'h5555, '0, 16'h5151);
    resume_seq("R3 resume");

    // R7: every channel, open only, short only, both
    for (int ch = 0; ch < NCH; ch++) begin
      for (int kind = 1; kind <= 3; kind++) begin
        a = (kind[0]) ? (NCH'(1) << ch) : '0;
        b = (kind[1]) ? (NCH'(1) << ch) : '0;
        enter_seq("R2 entry");
        run_window(WIN, '0, '0, a, b);
        resume_seq("R3 resume");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule